// File: doc/BRIEF.md
# Exception Entry Controller

This block holds the privileged exception state of a 32-bit in-order core and performs the state update when the pipeline takes an exception. The pipeline offers one exception request at a time. Each request carries a kind code, a load/store flag, the faulting PC, the PC that would have followed it, the bad virtual address and a coprocessor number. In the clock edge that accepts the request, the block updates Status, Cause, EPC, BadVAddr, EntryHi, Context and the shadow-set control register. One cycle later it presents the handler address on a redirect strobe.

The handler address depends on the state that held before entry. A TLB refill taken while the exception level is already raised goes to the general vector rather than the refill vector. An interrupt uses the dedicated offset when the interrupt-vector bit is set. An overflow taken while the boot vectors are selected goes to a fixed boot-region address. A delay-slot fault records the branch address in EPC and flags it in Cause.

The request interface is valid/ready. The controller never applies back-pressure: ready is low only while reset is asserted and through the first clock edge after release. From then on it is high every cycle, so a request is taken in the same cycle it is offered, and back-to-back requests are taken on consecutive edges. The redirect output is a plain one-cycle strobe with no handshake. Software reads the state through a combinational read port and writes it through a write port.

Top module: `exc_entry_ctrl`

## Requirements
- R1: `exc_ready` is low during reset and at the first clock edge after reset is released, and high on every later cycle. A request is taken at a clock edge where `exc_valid` and `exc_ready` are both high. The cycle after each taken request, `redirect_valid` is high for exactly one cycle. No other cycle raises it, except the boot redirect in R2.
- R2: After reset, Status reads CU1=1, BEV=1, EXL=0, IE=0, and EBASE reads 0x80000000. The cycle after the first edge following reset release, `redirect_valid` pulses once with `redirect_pc` = 0xBFC00000.
- R3: Every taken request sets Status.EXL (bit 1) to 1, whether or not it was already set.
- R4: If `exc_npc` differs from `exc_pc`+4, EPC becomes `exc_pc`-4 and Cause.BD (bit 31) becomes 1. Otherwise EPC becomes `exc_pc` and BD becomes 0.
- R5: Cause.ExcCode (bits 6:2) is loaded from the request kind (`exc_kind`: 0 interrupt, 1 TLB modified, 2 TLB refill, 3 TLB invalid, 4 address error, 5 syscall, 6 breakpoint, 7 reserved instruction, 8 coprocessor unusable, 9 overflow, 10 trap). The codes are: interrupt 0x0; TLB modified 0x1; TLB refill and TLB invalid 0x2 for a load and 0x3 for a store; address error 0x4 for a load and 0x5 for a store; syscall 0x8; breakpoint 0x9; reserved instruction 0xA; coprocessor unusable 0xB; overflow 0xC; trap 0xD.
- R6: Cause.CE (bits 29:28) becomes `exc_cop` for a coprocessor-unusable request and 0 for every other request.
- R7: Unless R8, R9 or R10 selects otherwise, the handler address is EBASE+0x180.
- R8: A TLB refill vectors to EBASE+0x000 when EXL was 0 before entry, and to EBASE+0x180 when EXL was already 1.
- R9: An interrupt vectors to EBASE+0x200 when Cause.IV (bit 23) is 1, and to EBASE+0x180 when it is 0.
- R10: An overflow taken while Status.BEV (bit 22) is 1 vectors to 0xBFC00200.
- R11: TLB modified, TLB refill, TLB invalid and address-error requests load BadVAddr with `exc_badva`. The three TLB kinds also load EntryHi.VPN2 (bits 31:13) and Context.BadVPN2 (bits 22:4) with `exc_badva[31:13]`. EntryHi.ASID (bits 7:0) and Context.PTEBase (bits 31:23) keep their values.
- R12: When EXL and BEV were both 0 before entry, the shadow-set register moves its current set (bits 3:0) into the previous set (bits 9:6) and its exception set (bits 15:12) into the current set. Otherwise the register is unchanged.
- R13: Software register addresses are: 0 Status, 1 Cause, 2 EPC, 3 BadVAddr, 4 EntryHi, 5 Context, 6 shadow-set control, 7 EBASE. The writable fields are:
  - Status: CU1 (bit 29), BEV, EXL and IE (bit 0).
  - Cause: IV.
  - EPC: all bits.
  - EntryHi: VPN2 and ASID.
  - Context: PTEBase.
  - Shadow-set control: the exception set and the previous set.
  - EBASE: bits 31:12. Its bits 11:0 always read 0.
  
  Every other bit reads 0 or holds hardware-written state, and BadVAddr is read-only.
- R14: A software write in a cycle in which a request is taken is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_valid | input | 1 | Exception request offered |
| exc_ready | output | 1 | Controller can take a request |
| exc_kind | input | 4 | Exception kind code |
| exc_store | input | 1 | Faulting access was a store |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_npc | input | 32 | PC that would follow it |
| exc_badva | input | 32 | Faulting virtual address |
| exc_cop | input | 2 | Coprocessor number for an unusable fault |
| sw_we | input | 1 | Software write strobe |
| sw_addr | input | 3 | Software write register address |
| sw_wdata | input | 32 | Software write data |
| sw_raddr | input | 3 | Software read register address |
| sw_rdata | output | 32 | Software read data (combinational) |
| redirect_valid | output | 1 | Handler address valid, one cycle |
| redirect_pc | output | 32 | Handler address |

## Verification
The hardest cases to reach are the ones whose outcome depends on the state left by the previous entry rather than on the current request. These are the refill-versus-general vector choice and the shadow-set swap being suppressed. The stimulus reaches them by issuing refill and overflow requests back to back, so the second one sees EXL already set by the first. It then clears EXL and BEV through the write port and repeats the same kinds. A software write to EBASE is also placed in the same cycle as a taken request, and the EBASE value read afterwards shows whether the write was dropped.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [3:0] {
    EK_INTR      = 4'd0,
    EK_TLB_MOD   = 4'd1,
    EK_TLB_REFIL = 4'd2,
    EK_TLB_INVAL = 4'd3,
    EK_ADDR_ERR  = 4'd4,
    EK_SYSCALL   = 4'd5,
    EK_BREAK     = 4'd6,
    EK_RESV_INSN = 4'd7,
    EK_COP_UNUSE = 4'd8,
    EK_OVERFLOW  = 4'd9,
    EK_TRAP      = 4'd10
  } exc_kind_e;

  // software register addresses
  localparam logic [2:0] RA_STATUS = 3'd0;
  localparam logic [2:0] RA_CAUSE  = 3'd1;
  localparam logic [2:0] RA_EPC    = 3'd2;
  localparam logic [2:0] RA_BADVA  = 3'd3;
  localparam logic [2:0] RA_ENTHI  = 3'd4;
  localparam logic [2:0] RA_CTX    = 3'd5;
  localparam logic [2:0] RA_SHADOW = 3'd6;
  localparam logic [2:0] RA_EBASE  = 3'd7;

  // field positions
  localparam int ST_CU1     = 29;
  localparam int ST_BEV     = 22;
  localparam int ST_EXL     = 1;
  localparam int ST_IE      = 0;
  localparam int CA_BD      = 31;
  localparam int CA_CE_LSB  = 28;
  localparam int CA_IV      = 23;
  localparam int CA_EC_LSB  = 2;
  localparam int SH_ESS_LSB = 12;
  localparam int SH_PSS_LSB = 6;
  localparam int SH_CSS_LSB = 0;
  localparam int VPN_LSB    = 13;
  localparam int CTX_VPN_LSB = 4;
  localparam int EB_LSB     = 12;
  localparam int EC_W       = 5;

endpackage

// File: rtl/exc_code_map.sv
module exc_code_map
  import exc_entry_pkg::*;
#(
  parameter int EC_WIDTH = EC_W
) (
  input  logic [3:0]          kind,
  input  logic                store,
  output logic [EC_WIDTH-1:0] code,
  output logic                ld_badva,
  output logic                ld_tlb,
  output logic                ld_cop
);

  exc_kind_e k;
  assign k = exc_kind_e'(kind);

  always_comb begin
    code     = EC_WIDTH'(5'h0A);
    ld_badva = 1'b0;
    ld_tlb   = 1'b0;
    ld_cop   = 1'b0;
    unique case (k)
      EK_INTR:      code = EC_WIDTH'(5'h00);
      EK_TLB_MOD: begin
        code = EC_WIDTH'(5'h01); ld_badva = 1'b1; ld_tlb = 1'b1;
      end
      EK_TLB_REFIL, EK_TLB_INVAL: begin
        code = store ? EC_WIDTH'(5'h03) : EC_WIDTH'(5'h02);
        ld_badva = 1'b1; ld_tlb = 1'b1;
      end
      EK_ADDR_ERR: begin
        code = store ? EC_WIDTH'(5'h05) : EC_WIDTH'(5'h04);
        ld_badva = 1'b1;
      end
      EK_SYSCALL:   code = EC_WIDTH'(5'h08);
      EK_BREAK:     code = EC_WIDTH'(5'h09);
      EK_RESV_INSN: code = EC_WIDTH'(5'h0A);
      EK_COP_UNUSE: begin code = EC_WIDTH'(5'h0B); ld_cop = 1'b1; end
      EK_OVERFLOW:  code = EC_WIDTH'(5'h0C);
      EK_TRAP:      code = EC_WIDTH'(5'h0D);
      default:      code = EC_WIDTH'(5'h0A);
    endcase
  end

endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_entry_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter logic [XLEN-1:0] BOOT_OVF_PC = 32'hBFC0_0200,
  parameter int              GEN_OFS     = 'h180,
  parameter int              IRQ_OFS     = 'h200,
  parameter int              REFILL_OFS  = 'h000
) (
  input  logic [3:0]      kind,
  input  logic [XLEN-1:0] ebase,
  input  logic            exl_before,
  input  logic            bev,
  input  logic            iv,
  output logic [XLEN-1:0] target
);

  exc_kind_e k;
  assign k = exc_kind_e'(kind);

  always_comb begin
    target = ebase + XLEN'(GEN_OFS);
    if (k == EK_TLB_REFIL && !exl_before)
      target = ebase + XLEN'(REFILL_OFS);
    else if (k == EK_INTR && iv)
      target = ebase + XLEN'(IRQ_OFS);
    else if (k == EK_OVERFLOW && bev)
      target = BOOT_OVF_PC;
  end

endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_entry_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              SET_W      = 4,
  parameter int              ASID_W     = 8,
  parameter int              COP_W      = 2,
  parameter int              INSN_BYTES = 4,
  parameter logic [XLEN-1:0] EBASE_RST  = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [EC_W-1:0]   code,
  input  logic              ld_badva,
  input  logic              ld_tlb,
  input  logic              ld_cop,
  input  logic [COP_W-1:0]  cop,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   npc,
  input  logic [XLEN-1:0]   badva,
  input  logic              sw_we,
  input  logic [2:0]        sw_addr,
  input  logic [XLEN-1:0]   sw_wdata,
  input  logic [2:0]        sw_raddr,
  output logic [XLEN-1:0]   sw_rdata,
  output logic [XLEN-1:0]   ebase,
  output logic              exl,
  output logic              bev,
  output logic              iv,
  output logic [SET_W-1:0]  css
);

  localparam int VPN_W   = XLEN - VPN_LSB;
  localparam int PTE_LSB = CTX_VPN_LSB + VPN_W;
  localparam int PTE_W   = XLEN - PTE_LSB;
  localparam int EB_W    = XLEN - EB_LSB;

  logic                st_cu1, st_bev, st_exl, st_ie;
  logic                ca_bd, ca_iv;
  logic [COP_W-1:0]    ca_ce;
  logic [EC_W-1:0]     ca_ec;
  logic [XLEN-1:0]     epc_q, badva_q;
  logic [VPN_W-1:0]    ehi_vpn, ctx_vpn;
  logic [ASID_W-1:0]   ehi_asid;
  logic [PTE_W-1:0]    ctx_pte;
  logic [SET_W-1:0]    sh_ess, sh_pss, sh_css;
  logic [EB_W-1:0]     eb_hi;

  logic                in_slot;
  logic [XLEN-1:0]     epc_next;
  logic                sw_wr;

  assign in_slot  = (npc != pc + XLEN'(INSN_BYTES));
  assign epc_next = in_slot ? pc - XLEN'(INSN_BYTES) : pc;
  assign sw_wr    = sw_we && !take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_cu1   <= 1'b1;
      st_bev   <= 1'b1;
      st_exl   <= 1'b0;
      st_ie    <= 1'b0;
      ca_bd    <= 1'b0;
      ca_iv    <= 1'b0;
      ca_ce    <= '0;
      ca_ec    <= '0;
      epc_q    <= '0;
      badva_q  <= '0;
      ehi_vpn  <= '0;
      ehi_asid <= '0;
      ctx_vpn  <= '0;
      ctx_pte  <= '0;
      sh_ess   <= '0;
      sh_pss   <= '0;
      sh_css   <= '0;
      eb_hi    <= EBASE_RST[XLEN-1:EB_LSB];
    end else if (take) begin
      if (!st_exl && !st_bev) begin
        sh_pss <= sh_css;
        sh_css <= sh_ess;
      end
      st_exl <= 1'b1;
      epc_q  <= epc_next;
      ca_bd  <= in_slot;
      ca_ec  <= code;
      ca_ce  <= ld_cop ? cop : '0;
      if (ld_badva) badva_q <= badva;
      if (ld_tlb) begin
        ehi_vpn <= badva[XLEN-1:VPN_LSB];
        ctx_vpn <= badva[XLEN-1:VPN_LSB];
      end
    end else if (sw_wr) begin
      unique case (sw_addr)
        RA_STATUS: begin
          st_cu1 <= sw_wdata[ST_CU1];
          st_bev <= sw_wdata[ST_BEV];
          st_exl <= sw_wdata[ST_EXL];
          st_ie  <= sw_wdata[ST_IE];
        end
        RA_CAUSE:  ca_iv <= sw_wdata[CA_IV];
        RA_EPC:    epc_q <= sw_wdata;
        RA_ENTHI: begin
          ehi_vpn  <= sw_wdata[XLEN-1:VPN_LSB];
          ehi_asid <= sw_wdata[ASID_W-1:0];
        end
        RA_CTX:    ctx_pte <= sw_wdata[XLEN-1:PTE_LSB];
        RA_SHADOW: begin
          sh_ess <= sw_wdata[SH_ESS_LSB +: SET_W];
          sh_pss <= sw_wdata[SH_PSS_LSB +: SET_W];
        end
        RA_EBASE:  eb_hi <= sw_wdata[XLEN-1:EB_LSB];
        default: ;
      endcase
    end
  end

  always_comb begin
    sw_rdata = '0;
    unique case (sw_raddr)
      RA_STATUS: begin
        sw_rdata[ST_CU1] = st_cu1;
        sw_rdata[ST_BEV] = st_bev;
        sw_rdata[ST_EXL] = st_exl;
        sw_rdata[ST_IE]  = st_ie;
      end
      RA_CAUSE: begin
        sw_rdata[CA_BD]                = ca_bd;
        sw_rdata[CA_CE_LSB +: COP_W]   = ca_ce;
        sw_rdata[CA_IV]                = ca_iv;
        sw_rdata[CA_EC_LSB +: EC_W]    = ca_ec;
      end
      RA_EPC:   sw_rdata = epc_q;
      RA_BADVA: sw_rdata = badva_q;
      RA_ENTHI: begin
        sw_rdata[XLEN-1:VPN_LSB] = ehi_vpn;
        sw_rdata[ASID_W-1:0]     = ehi_asid;
      end
      RA_CTX: begin
        sw_rdata[XLEN-1:PTE_LSB]         = ctx_pte;
        sw_rdata[CTX_VPN_LSB +: VPN_W]   = ctx_vpn;
      end
      RA_SHADOW: begin
        sw_rdata[SH_ESS_LSB +: SET_W] = sh_ess;
        sw_rdata[SH_PSS_LSB +: SET_W] = sh_pss;
        sw_rdata[SH_CSS_LSB +: SET_W] = sh_css;
      end
      RA_EBASE: sw_rdata = ebase;
      default: ;
    endcase
  end

  assign ebase = {eb_hi, {EB_LSB{1'b0}}};
  assign exl   = st_exl;
  assign bev   = st_bev;
  assign iv    = ca_iv;
  assign css   = sh_css;

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter int          SET_W       = 4,
  parameter int          ASID_W      = 8,
  parameter int          COP_W       = 2,
  parameter int          INSN_BYTES  = 4,
  parameter logic [31:0] RESET_PC    = 32'hBFC0_0000,
  parameter logic [31:0] BOOT_OVF_PC = 32'hBFC0_0200,
  parameter logic [31:0] EBASE_RST   = 32'h8000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_valid,
  output logic             exc_ready,
  input  logic [3:0]       exc_kind,
  input  logic             exc_store,
  input  logic [XLEN-1:0]  exc_pc,
  input  logic [XLEN-1:0]  exc_npc,
  input  logic [XLEN-1:0]  exc_badva,
  input  logic [COP_W-1:0] exc_cop,
  input  logic             sw_we,
  input  logic [2:0]       sw_addr,
  input  logic [XLEN-1:0]  sw_wdata,
  input  logic [2:0]       sw_raddr,
  output logic [XLEN-1:0]  sw_rdata,
  output logic             redirect_valid,
  output logic [XLEN-1:0]  redirect_pc
);

  logic             rdy_q, boot_q, take;
  logic [EC_W-1:0]  code;
  logic             ld_badva, ld_tlb, ld_cop;
  logic [XLEN-1:0]  ebase, target;
  logic             exl, bev, iv;
  logic [SET_W-1:0] css;

  assign exc_ready = rdy_q;
  assign take      = exc_valid && rdy_q;

  exc_code_map #(.EC_WIDTH(EC_W)) u_map (
    .kind     (exc_kind),
    .store    (exc_store),
    .code     (code),
    .ld_badva (ld_badva),
    .ld_tlb   (ld_tlb),
    .ld_cop   (ld_cop)
  );

  exc_vector_sel #(.XLEN(XLEN), .BOOT_OVF_PC(BOOT_OVF_PC[XLEN-1:0])) u_vec (
    .kind       (exc_kind),
    .ebase      (ebase),
    .exl_before (exl),
    .bev        (bev),
    .iv         (iv),
    .target     (target)
  );

  exc_state_regs #(
    .XLEN(XLEN), .SET_W(SET_W), .ASID_W(ASID_W), .COP_W(COP_W),
    .INSN_BYTES(INSN_BYTES), .EBASE_RST(EBASE_RST[XLEN-1:0])
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .code     (code),
    .ld_badva (ld_badva),
    .ld_tlb   (ld_tlb),
    .ld_cop   (ld_cop),
    .cop      (exc_cop),
    .pc       (exc_pc),
    .npc      (exc_npc),
    .badva    (exc_badva),
    .sw_we    (sw_we),
    .sw_addr  (sw_addr),
    .sw_wdata (sw_wdata),
    .sw_raddr (sw_raddr),
    .sw_rdata (sw_rdata),
    .ebase    (ebase),
    .exl      (exl),
    .bev      (bev),
    .iv       (iv),
    .css      (css)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q          <= 1'b0;
      boot_q         <= 1'b1;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
    end else begin
      rdy_q          <= 1'b1;
      boot_q         <= 1'b0;
      redirect_valid <= take || boot_q;
      if (boot_q)    redirect_pc <= RESET_PC[XLEN-1:0];
      else if (take) redirect_pc <= target;
    end
  end

endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk #(
  parameter int          XLEN     = 32,
  parameter int          SET_W    = 4,
  parameter logic [31:0] RESET_PC = 32'hBFC0_0000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             take,
  input logic             boot_q,
  input logic             redirect_valid,
  input logic [XLEN-1:0]  redirect_pc,
  input logic             exl,
  input logic [XLEN-1:0]  ebase,
  input logic [SET_W-1:0] css,
  input logic [3:0]       kind,
  input logic             sw_we,
  input logic [2:0]       sw_addr
);

  AST_REDIRECT_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n) take |=> redirect_valid); // R1
  AST_NO_STRAY_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n) (!take && !boot_q) |=> !redirect_valid); // R1
  AST_BOOT_TARGET: assert property (@(posedge clk) disable iff (!rst_n) boot_q |=> (redirect_valid && redirect_pc == RESET_PC[XLEN-1:0])); // R2
  AST_EXL_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) take |=> exl); // R3
  AST_REFILL_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n) (take && kind == 4'd2 && !exl) |=> (redirect_pc == $past(ebase))); // R8
  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n) (take && exl) |=> $stable(css)); // R12
  AST_EBASE_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) (take && sw_we && sw_addr == 3'd7) |=> $stable(ebase)); // R14

endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(
  .XLEN(XLEN), .SET_W(SET_W), .RESET_PC(RESET_PC)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .take           (take),
  .boot_q         (boot_q),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .exl            (exl),
  .ebase          (ebase),
  .css            (css),
  .kind           (exc_kind),
  .sw_we          (sw_we),
  .sw_addr        (sw_addr)
);

// File: tb/exc_entry_ctrl_bench.sv
`timescale 1ns/1ps
module exc_entry_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic        exc_ready;
  logic [3:0]  exc_kind = 4'd0;
  logic        exc_store = 1'b0;
  logic [31:0] exc_pc = 32'd0;
  logic [31:0] exc_npc = 32'd4;
  logic [31:0] exc_badva = 32'd0;
  logic [1:0]  exc_cop = 2'd0;
  logic        sw_we = 1'b0;
  logic [2:0]  sw_addr = 3'd0;
  logic [31:0] sw_wdata = 32'd0;
  logic [2:0]  sw_raddr = 3'd0;
  logic [31:0] sw_rdata;
  logic        redirect_valid;
  logic [31:0] redirect_pc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  exc_entry_ctrl u_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n),
    .exc_valid(exc_valid), .exc_ready(exc_ready), .exc_kind(exc_kind),
    .exc_store(exc_store), .exc_pc(exc_pc), .exc_npc(exc_npc),
    .exc_badva(exc_badva), .exc_cop(exc_cop),
    .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
    .sw_raddr(sw_raddr), .sw_rdata(sw_rdata),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  // ---------------- reference model ----------------
  logic m_cu1 = 1, m_bev = 1, m_exl = 0, m_ie = 0;
  logic m_bd = 0, m_iv = 0;
  logic [1:0]  m_ce = 0;
  logic [4:0]  m_ec = 0;
  logic [31:0] m_epc = 0, m_badva = 0, m_ebase = 32'h8000_0000;
  logic [18:0] m_vpn = 0, m_cvpn = 0;
  logic [7:0]  m_asid = 0;
  logic [8:0]  m_pte = 0;
  logic [3:0]  m_ess = 0, m_pss = 0, m_css = 0;
  logic        m_rdy = 0, m_boot = 1, m_rv = 0;
  logic [31:0] m_rpc = 0;
  bit          started = 0;

  function automatic logic [4:0] ref_code(int k, logic st);
    case (k)
      0: return 5'h00;
      1: return 5'h01;
      2, 3: return st ? 5'h03 : 5'h02;
      4: return st ? 5'h05 : 5'h04;
      5: return 5'h08;
      6: return 5'h09;
      8: return 5'h0B;
      9: return 5'h0C;
      10: return 5'h0D;
      default: return 5'h0A;
    endcase
  endfunction

  function automatic logic [31:0] ref_read(logic [2:0] a);
    case (a)
      3'd0: return (32'(m_cu1) << 29) | (32'(m_bev) << 22) | (32'(m_exl) << 1) | 32'(m_ie);
      3'd1: return (32'(m_bd) << 31) | (32'(m_ce) << 28) | (32'(m_iv) << 23) | (32'(m_ec) << 2);
      3'd2: return m_epc;
      3'd3: return m_badva;
      3'd4: return (32'(m_vpn) << 13) | 32'(m_asid);
      3'd5: return (32'(m_pte) << 23) | (32'(m_cvpn) << 4);
      3'd6: return (32'(m_ess) << 12) | (32'(m_pss) << 6) | 32'(m_css);
      default: return m_ebase;
    endcase
  endfunction

  function automatic string reg_tag(logic [2:0] a);
    case (a)
      3'd0: return "R2 R3 R13";
      3'd1: return "R5 R6 R4";
      3'd2: return "R4";
      3'd3: return "R11";
      3'd4: return "R11 R13";
      3'd5: return "R11 R13";
      3'd6: return "R12";
      default: return "R13 R14";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cu1 = 1; m_bev = 1; m_exl = 0; m_ie = 0; m_bd = 0; m_iv = 0; m_ce = 0; m_ec = 0;
      m_epc = 0; m_badva = 0; m_ebase = 32'h8000_0000; m_vpn = 0; m_cvpn = 0; m_asid = 0;
      m_pte = 0; m_ess = 0; m_pss = 0; m_css = 0; m_rdy = 0; m_boot = 1; m_rv = 0;
    end else begin
      bit tk;
      tk = exc_valid && m_rdy;
      m_rv = tk || m_boot;
      if (m_boot) m_rpc = 32'hBFC0_0000;
      else if (tk) begin
        int k;
        k = int'(exc_kind);
        if (k == 2 && !m_exl)       m_rpc = m_ebase;
        else if (k == 0 && m_iv)    m_rpc = m_ebase + 32'h200;
        else if (k == 9 && m_bev)   m_rpc = 32'hBFC0_0200;
        else                        m_rpc = m_ebase + 32'h180;
        if (!m_exl && !m_bev) begin m_pss = m_css; m_css = m_ess; end
        m_exl = 1;
        m_bd  = (exc_npc != exc_pc + 32'd4);
        m_epc = m_bd ? exc_pc - 32'd4 : exc_pc;
        m_ec  = ref_code(k, exc_store);
        m_ce  = (k == 8) ? exc_cop : 2'd0;
        if (k >= 1 && k <= 4) m_badva = exc_badva;
        if (k >= 1 && k <= 3) begin m_vpn = exc_badva[31:13]; m_cvpn = exc_badva[31:13]; end
      end
      if (!tk && sw_we) begin
        case (sw_addr)
          3'd0: begin m_cu1 = sw_wdata[29]; m_bev = sw_wdata[22]; m_exl = sw_wdata[1]; m_ie = sw_wdata[0]; end
          3'd1: m_iv = sw_wdata[23];
          3'd2: m_epc = sw_wdata;
          3'd4: begin m_vpn = sw_wdata[31:13]; m_asid = sw_wdata[7:0]; end
          3'd5: m_pte = sw_wdata[31:23];
          3'd6: begin m_ess = sw_wdata[15:12]; m_pss = sw_wdata[9:6]; end
          3'd7: m_ebase = {sw_wdata[31:12], 12'h000};
          default: ;
        endcase
      end
      m_rdy = 1; m_boot = 0;
    end
    started = 1;
  end

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every clock, away from the rising edge
  always @(negedge clk) begin
    if (started && !done) begin
      check("R1", "exc_ready", 32'(exc_ready), 32'(m_rdy));
      check("R1 R2", "redirect_valid", 32'(redirect_valid), 32'(m_rv));
      if (m_rv) check("R2 R7 R8 R9 R10", "redirect_pc", redirect_pc, m_rpc);
      check(reg_tag(sw_raddr), "sw_rdata", sw_rdata, ref_read(sw_raddr));
    end
  end

  // read address sweeps all registers
  always @(negedge clk) begin
    #2 sw_raddr <= sw_raddr + 3'd1;
  end

  // ---------------- stimulus ----------------
  task automatic fire(int k, logic st, logic [31:0] pc, logic [31:0] npc,
                      logic [31:0] bva, logic [1:0] cop);
    @(negedge clk); #1;
    exc_valid = 1; exc_kind = 4'(k); exc_store = st; exc_pc = pc;
    exc_npc = npc; exc_badva = bva; exc_cop = cop; sw_we = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); #1;
    exc_valid = 0; sw_we = 1; sw_addr = a; sw_wdata = d;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk); #1;
      exc_valid = 0; sw_we = 0;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(10);                                         // R2 boot redirect, reset values
    wr(3'd0, 32'h2000_0001);                          // R13 clear BEV, keep CU1, IE
    wr(3'd6, 32'h0000_5000);                          // R12 exception set 5
    wr(3'd4, 32'h0000_00A5);                          // R13 ASID
    wr(3'd5, 32'hFF80_0000);                          // R13 PTEBase
    idle(8);
    fire(5, 0, 32'h0000_1000, 32'h0000_1004, 0, 0);   // R5 syscall, R12 swap, R4 no slot
    idle(8);
    wr(3'd0, 32'h2000_0000);                          // clear EXL
    fire(6, 0, 32'h0000_1100, 32'h0000_2000, 0, 0);   // R4 delay slot breakpoint
    idle(8);
    wr(3'd0, 32'h2000_0000);
    fire(2, 0, 32'h0000_3000, 32'h0000_3004, 32'h1234_5678, 0); // R8 refill, EXL clear
    fire(2, 1, 32'h0000_3010, 32'h0000_3014, 32'hCAFE_E000, 0); // R8 refill, EXL set
    idle(8);
    wr(3'd0, 32'h2000_0000);
    wr(3'd1, 32'h0080_0000);                          // R9 IV on
    fire(0, 0, 32'h0000_4000, 32'h0000_4004, 0, 0);
    idle(4);
    wr(3'd0, 32'h2000_0000);
    wr(3'd1, 32'h0000_0000);                          // R9 IV off
    fire(0, 0, 32'h0000_4100, 32'h0000_4104, 0, 0);
    idle(8);
    wr(3'd0, 32'h2040_0000);                          // R10 BEV on
    fire(9, 0, 32'h0000_5000, 32'h0000_5004, 0, 0);
    fire(9, 0, 32'h0000_5010, 32'h0000_6000, 0, 0);   // R12 no swap when EXL set
    idle(8);
    wr(3'd7, 32'h9000_0ABC);                          // R13 EBASE low bits read zero
    wr(3'd0, 32'h0000_0000);
    fire(9, 0, 32'h0000_5100, 32'h0000_5104, 0, 0);   // R7 overflow BEV clear
    idle(8);
    fire(8, 0, 32'h0000_6000, 32'h0000_6004, 0, 2'd3); // R6 coprocessor id
    fire(4, 1, 32'h0000_6100, 32'h0000_6104, 32'h0BAD_0001, 2'd3); // R6 CE cleared, R11
    fire(4, 0, 32'h0000_6200, 32'h0000_6204, 32'h0BAD_0002, 0);
    idle(8);
    // R14 software write in the taking cycle is dropped
    @(negedge clk); #1;
    exc_valid = 1; exc_kind = 4'd10; exc_pc = 32'h7000; exc_npc = 32'h7004;
    sw_we = 1; sw_addr = 3'd7; sw_wdata = 32'hA000_0000;
    idle(8);
    fire(3, 1, 32'h0000_8000, 32'h0000_8004, 32'h7654_3210, 0); // R11 TLB invalid store
    fire(1, 0, 32'h0000_8100, 32'h0000_8104, 32'h1111_3333, 0); // R11 TLB modified
    fire(7, 0, 32'h0000_8200, 32'h0000_8204, 32'hFFFF_FFFF, 0); // R11 no badva load
    fire(13, 0, 32'h0000_8300, 32'h0000_8304, 0, 0);
    idle(8);
    wr(3'd2, 32'h0000_ABCC);                          // R13 EPC write
    wr(3'd3, 32'h5555_5555);                          // R13 BadVAddr read-only
    idle(10);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule